// File: doc/BRIEF.md
# Split-Screen LCD Refresh Address Generator

This block turns the row and column counters of an LCD refresh engine into a frame-buffer fetch address. The panel is split into three horizontal bands, each read from its own window of memory. The top band and the bottom band each have a start and an end address and their own enable. The remainder band has only a start address. By default the remainder band covers the whole panel. Turning on the top band pushes the remainder content downward. Turning on the bottom band covers the lowest remainder lines and does not move them.

The remainder band's memory holds twice the visible width per line, so that a horizontal pan offset can slide the visible window sideways. The top and bottom bands are packed with a line stride equal to the visible width. A band's height in lines is derived from its address span. All configuration is captured on the first cycle of vertical blanking. The band heights are counted during the rest of blanking, so one frame never mixes two settings. A tag output names the band that produced each address.

Top module: `lcd_split_addr_gen`

## Requirements
- R1: While reset is asserted, `region_tag_o` is 0 and `fetch_addr_o` is 0. Tag codes are 0 none, 1 top, 2 bottom, 3 remainder.
- R2: A cycle with `vblank_i` high gives tag 0 and address 0 on the following cycle.
- R3: With both the top and bottom bands disabled, every row gives tag 3 and address `c_start + row*2*width + pan + col`.
- R4: The top band's line count is min((a_end − a_start)/width + 1, height), using integer division. When the top band is enabled, rows below that count give tag 1 and address `a_start + row*width + col`.
- R5: With the top band enabled and its line count L, a remainder row r gives address `c_start + (r − L)*2*width + pan + col`.
- R6: The bottom band's line count Lb is formed in the same way as in R4. When the bottom band is enabled, rows r ≥ height − Lb give tag 2 and address `b_start + (r − (height − Lb))*width + col`. The bottom band does not change how remainder rows are numbered.
- R7: Where the top and bottom bands claim the same row, the top band wins.
- R8: Configuration inputs are sampled only on the first cycle of a blanking interval. Changes at any other time have no effect until the next blanking interval.
- R9: The pan offset is added only to remainder-band addresses.
- R10: Outputs are registered. The address and tag for the inputs of cycle t appear in cycle t+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vblank_i | input | 1 | Vertical blanking flag from display timing |
| a_en_i | input | 1 | Top band enable |
| b_en_i | input | 1 | Bottom band enable |
| a_start_i | input | ADDR_W | Top band first address |
| a_end_i | input | ADDR_W | Top band last address |
| b_start_i | input | ADDR_W | Bottom band first address |
| b_end_i | input | ADDR_W | Bottom band last address |
| c_start_i | input | ADDR_W | Remainder band first address |
| pan_i | input | PAN_W | Horizontal pan offset for the remainder band |
| height_i | input | ROW_W | Panel height in lines |
| width_i | input | COL_W | Visible panel width in address units |
| row_i | input | ROW_W | Current display row |
| col_i | input | COL_W | Current display column |
| fetch_addr_o | output | ADDR_W | Frame-buffer fetch address |
| region_tag_o | output | 2 | Band that produced the address |

## Verification
The assertions assume a blanking interval lasts at least height plus three cycles, so the band line counters finish before the first active row. They also assume that during active display the row stays below the height and the column below the width, that each end address is not below its start address, and that the width is nonzero. The stimulus holds each blanking interval for height plus six cycles and walks every row and column of each frame within the panel size. It keeps the end addresses at or above the start addresses, including the case where the line count saturates at the panel height. The reference model derives band heights by integer division, which is independent of the block's subtraction counter.

// File: rtl/lcd_split_pkg.sv
package lcd_split_pkg;
  typedef enum logic [1:0] {
    TAG_NONE = 2'd0,
    TAG_A    = 2'd1,
    TAG_B    = 2'd2,
    TAG_C    = 2'd3
  } region_tag_e;
endpackage

// File: rtl/lcd_line_counter.sv
// Counts how many width-sized lines fit into an address span, saturating at
// the panel height. One line is added per cycle after start_i.
module lcd_line_counter #(
  parameter int ADDR_W = 24,
  parameter int ROW_W  = 10,
  parameter int COL_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] first_addr_i,
  input  logic [ADDR_W-1:0] last_addr_i,
  input  logic [COL_W-1:0]  stride_i,
  input  logic [ROW_W-1:0]  height_i,
  output logic [ROW_W-1:0]  lines_o,
  output logic              busy_o
);
  logic [ADDR_W-1:0] rem_q, rem_d;
  logic [ROW_W-1:0]  lines_q, lines_d;
  logic              busy_q, busy_d;
  logic [ADDR_W-1:0] stride_ext;

  assign stride_ext = ADDR_W'(stride_i);

  always_comb begin
    rem_d   = rem_q;
    lines_d = lines_q;
    busy_d  = busy_q;
    if (start_i) begin
      rem_d   = last_addr_i - first_addr_i;
      lines_d = (height_i != '0) ? ROW_W'(1) : '0;
      busy_d  = 1'b1;
    end else if (busy_q) begin
      if ((rem_q >= stride_ext) && (lines_q < height_i)) begin
        rem_d   = rem_q - stride_ext;
        lines_d = lines_q + ROW_W'(1);
      end else begin
        busy_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q   <= '0;
      lines_q <= '0;
      busy_q  <= 1'b0;
    end else begin
      rem_q   <= rem_d;
      lines_q <= lines_d;
      busy_q  <= busy_d;
    end
  end

  assign lines_o = lines_q;
  assign busy_o  = busy_q;

  // R4: the count never passes the panel height once settled
  assert_lines_bounded_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |-> (lines_q <= height_i));

  // R4: a settled count holds until the next start
  assert_count_settled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> $stable(lines_q));
endmodule

// File: rtl/lcd_region_select.sv
// Chooses the band for a row (top over bottom over remainder) and gives the
// row index inside that band.
module lcd_region_select
  import lcd_split_pkg::*;
#(
  parameter int ROW_W = 10
) (
  input  logic [ROW_W-1:0] row_i,
  input  logic [ROW_W-1:0] height_i,
  input  logic             a_en_i,
  input  logic             b_en_i,
  input  logic [ROW_W-1:0] a_lines_i,
  input  logic [ROW_W-1:0] b_lines_i,
  output region_tag_e      tag_o,
  output logic [ROW_W-1:0] sub_row_o
);
  logic [ROW_W-1:0] b_top;
  logic             a_hit, b_hit;

  assign b_top = height_i - b_lines_i;
  assign a_hit = a_en_i && (row_i < a_lines_i);
  assign b_hit = b_en_i && (row_i >= b_top);

  always_comb begin
    if (a_hit) begin
      tag_o     = TAG_A;
      sub_row_o = row_i;
    end else if (b_hit) begin
      tag_o     = TAG_B;
      sub_row_o = row_i - b_top;
    end else begin
      tag_o     = TAG_C;
      sub_row_o = a_en_i ? (row_i - a_lines_i) : row_i;
    end
  end
endmodule

// File: rtl/lcd_addr_calc.sv
// Forms the fetch address from the band base, line index, stride, column and pan.
module lcd_addr_calc
  import lcd_split_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int ROW_W  = 10,
  parameter int COL_W  = 10,
  parameter int PAN_W  = 8
) (
  input  region_tag_e       tag_i,
  input  logic [ROW_W-1:0]  sub_row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [COL_W-1:0]  width_i,
  input  logic [ADDR_W-1:0] a_start_i,
  input  logic [ADDR_W-1:0] b_start_i,
  input  logic [ADDR_W-1:0] c_start_i,
  input  logic [PAN_W-1:0]  pan_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int STRIDE_W = COL_W + 1;
  localparam int PROD_W   = ROW_W + STRIDE_W;

  logic [STRIDE_W-1:0] stride;
  logic [PROD_W-1:0]   line_off;
  logic [ADDR_W-1:0]   base;
  logic [ADDR_W-1:0]   pan_add;

  always_comb begin
    stride  = {1'b0, width_i};
    base    = c_start_i;
    pan_add = '0;
    unique case (tag_i)
      TAG_A: base = a_start_i;
      TAG_B: base = b_start_i;
      default: begin
        stride  = {width_i, 1'b0};
        base    = c_start_i;
        pan_add = ADDR_W'(pan_i);
      end
    endcase
  end

  assign line_off = PROD_W'(sub_row_i) * PROD_W'(stride);
  assign addr_o   = base + ADDR_W'(line_off) + ADDR_W'(col_i) + pan_add;
endmodule

// File: rtl/lcd_split_addr_gen.sv
module lcd_split_addr_gen
  import lcd_split_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int ROW_W  = 10,
  parameter int COL_W  = 10,
  parameter int PAN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vblank_i,
  input  logic              a_en_i,
  input  logic              b_en_i,
  input  logic [ADDR_W-1:0] a_start_i,
  input  logic [ADDR_W-1:0] a_end_i,
  input  logic [ADDR_W-1:0] b_start_i,
  input  logic [ADDR_W-1:0] b_end_i,
  input  logic [ADDR_W-1:0] c_start_i,
  input  logic [PAN_W-1:0]  pan_i,
  input  logic [ROW_W-1:0]  height_i,
  input  logic [COL_W-1:0]  width_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [1:0]        region_tag_o
);
  localparam int NUM_BANDS = 2;

  // frame-stable copy of the configuration
  logic              sh_a_en, sh_b_en;
  logic [ADDR_W-1:0] sh_a_start, sh_a_end, sh_b_start, sh_b_end, sh_c_start;
  logic [PAN_W-1:0]  sh_pan;
  logic [ROW_W-1:0]  sh_height;
  logic [COL_W-1:0]  sh_width;

  logic vblank_q, load, count_start_q;

  assign load = vblank_i && !vblank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vblank_q      <= 1'b0;
      count_start_q <= 1'b0;
    end else begin
      vblank_q      <= vblank_i;
      count_start_q <= load;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_a_en    <= 1'b0;
      sh_b_en    <= 1'b0;
      sh_a_start <= '0;
      sh_a_end   <= '0;
      sh_b_start <= '0;
      sh_b_end   <= '0;
      sh_c_start <= '0;
      sh_pan     <= '0;
      sh_height  <= '0;
      sh_width   <= '0;
    end else if (load) begin
      sh_a_en    <= a_en_i;
      sh_b_en    <= b_en_i;
      sh_a_start <= a_start_i;
      sh_a_end   <= a_end_i;
      sh_b_start <= b_start_i;
      sh_b_end   <= b_end_i;
      sh_c_start <= c_start_i;
      sh_pan     <= pan_i;
      sh_height  <= height_i;
      sh_width   <= width_i;
    end
  end

  // per-band line counters (index 0 top, 1 bottom)
  logic [ADDR_W-1:0] band_first [NUM_BANDS];
  logic [ADDR_W-1:0] band_last  [NUM_BANDS];
  logic [ROW_W-1:0]  band_lines [NUM_BANDS];
  logic              band_busy  [NUM_BANDS];

  assign band_first[0] = sh_a_start;
  assign band_last[0]  = sh_a_end;
  assign band_first[1] = sh_b_start;
  assign band_last[1]  = sh_b_end;

  for (genvar g = 0; g < NUM_BANDS; g++) begin : g_band
    lcd_line_counter #(
      .ADDR_W(ADDR_W),
      .ROW_W (ROW_W),
      .COL_W (COL_W)
    ) u_lines (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_i     (count_start_q),
      .first_addr_i(band_first[g]),
      .last_addr_i (band_last[g]),
      .stride_i    (sh_width),
      .height_i    (sh_height),
      .lines_o     (band_lines[g]),
      .busy_o      (band_busy[g])
    );
  end

  region_tag_e      sel_tag;
  logic [ROW_W-1:0] sub_row;
  logic [ADDR_W-1:0] calc_addr;

  lcd_region_select #(.ROW_W(ROW_W)) u_select (
    .row_i    (row_i),
    .height_i (sh_height),
    .a_en_i   (sh_a_en),
    .b_en_i   (sh_b_en),
    .a_lines_i(band_lines[0]),
    .b_lines_i(band_lines[1]),
    .tag_o    (sel_tag),
    .sub_row_o(sub_row)
  );

  lcd_addr_calc #(
    .ADDR_W(ADDR_W),
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .PAN_W (PAN_W)
  ) u_calc (
    .tag_i    (sel_tag),
    .sub_row_i(sub_row),
    .col_i    (col_i),
    .width_i  (sh_width),
    .a_start_i(sh_a_start),
    .b_start_i(sh_b_start),
    .c_start_i(sh_c_start),
    .pan_i    (sh_pan),
    .addr_o   (calc_addr)
  );

  // output stage
  logic [ADDR_W-1:0] addr_d, addr_q;
  region_tag_e       tag_d, tag_q;

  always_comb begin
    if (vblank_i) begin
      addr_d = '0;
      tag_d  = TAG_NONE;
    end else begin
      addr_d = calc_addr;
      tag_d  = sel_tag;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      tag_q  <= TAG_NONE;
    end else begin
      addr_q <= addr_d;
      tag_q  <= tag_d;
    end
  end

  assign fetch_addr_o = addr_q;
  assign region_tag_o = tag_q;

  // R2: blanking yields an idle output on the next cycle
  assert_blank_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_i |=> (region_tag_o == 2'd0 && fetch_addr_o == '0));

  // R8: the frame copy cannot move outside the first blanking cycle
  assert_cfg_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> ($stable(sh_a_start) && $stable(sh_b_start) && $stable(sh_c_start)
               && $stable(sh_a_en) && $stable(sh_b_en) && $stable(sh_pan)
               && $stable(sh_width) && $stable(sh_height)));

  // R4: top band's first fetch is its start address
  assert_top_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vblank_i && !band_busy[0] && sh_a_en && band_lines[0] != '0
     && row_i == '0 && col_i == '0)
    |=> (fetch_addr_o == $past(sh_a_start) && region_tag_o == 2'd1));

  // R7: rows inside the top band never report another band
  assert_top_priority_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vblank_i && !band_busy[0] && sh_a_en && row_i < band_lines[0])
    |=> region_tag_o == 2'd1);

  // R6: bottom tag only appears while that band is enabled
  assert_bottom_enabled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (region_tag_o == 2'd2) |-> sh_b_en);
endmodule

// File: tb/lcd_split_addr_gen_tb.sv
module lcd_split_addr_gen_tb;
  localparam int ADDR_W = 24;
  localparam int ROW_W  = 10;
  localparam int COL_W  = 10;
  localparam int PAN_W  = 8;
  localparam longint AMASK = (64'd1 << ADDR_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              vblank;
  logic              a_en, b_en;
  logic [ADDR_W-1:0] a_start, a_end, b_start, b_end, c_start;
  logic [PAN_W-1:0]  pan;
  logic [ROW_W-1:0]  height, row;
  logic [COL_W-1:0]  width, col;
  logic [ADDR_W-1:0] fetch_addr;
  logic [1:0]        tag;

  always #5 clk = ~clk;

  lcd_split_addr_gen #(
    .ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W), .PAN_W(PAN_W)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .vblank_i(vblank),
    .a_en_i(a_en), .b_en_i(b_en),
    .a_start_i(a_start), .a_end_i(a_end),
    .b_start_i(b_start), .b_end_i(b_end), .c_start_i(c_start),
    .pan_i(pan), .height_i(height), .width_i(width),
    .row_i(row), .col_i(col),
    .fetch_addr_o(fetch_addr), .region_tag_o(tag)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // model copy of the frame configuration
  int     m_a_en, m_b_en, m_h, m_w, m_pan;
  longint m_a_start, m_a_end, m_b_start, m_b_end, m_c_start;
  bit     prev_vb;
  int     exp_tag;
  longint exp_addr;

  function automatic int band_lines(longint s, longint e, int w, int h);
    longint n;
    n = (e - s) / w + 1;
    if (n > h) n = h;
    return int'(n);
  endfunction

  task automatic model_load();
    m_a_en = a_en; m_b_en = b_en; m_h = height; m_w = width; m_pan = pan;
    m_a_start = a_start; m_a_end = a_end; m_b_start = b_start;
    m_b_end = b_end; m_c_start = c_start;
  endtask

  task automatic model_eval(input int r, input int c);
    int la, lb, top_b;
    la = band_lines(m_a_start, m_a_end, m_w, m_h);
    lb = band_lines(m_b_start, m_b_end, m_w, m_h);
    top_b = m_h - lb;
    if (m_a_en != 0 && r < la) begin
      exp_tag = 1; exp_addr = m_a_start + r * m_w + c;
    end else if (m_b_en != 0 && r >= top_b) begin
      exp_tag = 2; exp_addr = m_b_start + (r - top_b) * m_w + c;
    end else begin
      exp_tag = 3;
      exp_addr = m_c_start + ((m_a_en != 0) ? (r - la) : r) * 2 * m_w + m_pan + c;
    end
    exp_addr = exp_addr & AMASK;
  endtask

  task automatic check(input string req);
    n_chk++;
    if (tag !== exp_tag[1:0] || fetch_addr !== exp_addr[ADDR_W-1:0]) begin
      n_bad++;
      $display("FAIL %s: actual tag=%0d addr=%h expected tag=%0d addr=%h",
               req, tag, fetch_addr, exp_tag, exp_addr[ADDR_W-1:0]);
    end
  endtask

  // one clock: drive at negedge, model at posedge, check at next negedge (R10)
  task automatic tick(input bit vb, input int r, input int c, input string lbl);
    string req;
    vblank = vb; row = ROW_W'(r); col = COL_W'(c);
    @(posedge clk);
    if (vb && !prev_vb) model_load();
    prev_vb = vb;
    if (vb) begin
      exp_tag = 0; exp_addr = 0; req = "R2";
    end else begin
      model_eval(r, c);
      req = (exp_tag == 1) ? "R4" : (exp_tag == 2) ? "R6" : "R3";
    end
    @(negedge clk);
    check({req, " R10 ", lbl});
  endtask

  task automatic run_frame(input string lbl, input bit scramble);
    int nvb;
    nvb = int'(height) + 6;
    for (int i = 0; i < nvb; i++) begin
      tick(1'b1, 0, 0, lbl);
      if (scramble && i == 0) begin
        // R8: changes after the first blanking cycle must be ignored
        a_en = ~a_en; b_en = ~b_en; a_start = a_start + 24'h333;
        c_start = c_start ^ 24'h0F0F0; pan = pan + 8'd9; width = width + 10'd1;
        height = height - 10'd1; b_start = b_start + 24'h10;
      end
    end
    for (int r = 0; r < m_h; r++)
      for (int c = 0; c < m_w; c++) begin
        if (scramble && r == 2 && c == 0) begin
          a_start = 24'h777; a_end = 24'h7FF; c_start = 24'h5555; pan = 8'd77;
        end
        tick(1'b0, r, c, lbl);
      end
  endtask

  initial begin
    rst_n = 1'b0; vblank = 1'b0; a_en = 0; b_en = 0;
    a_start = '0; a_end = '0; b_start = '0; b_end = '0; c_start = '0;
    pan = '0; height = 10'd8; width = 10'd6; row = '0; col = '0;
    prev_vb = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    exp_tag = 0; exp_addr = 0;
    check("R1 reset");
    rst_n = 1'b1;

    // R3 R9: remainder band alone, with pan
    a_en = 0; b_en = 0; c_start = 24'h001000; pan = 8'd3; height = 10'd8; width = 10'd6;
    run_frame("R3 R9 all-remainder", 0);

    // R4 R5: top band of 3 lines shifts remainder down
    a_en = 1; b_en = 0; a_start = 24'h000200; a_end = 24'h000200 + 24'd17;
    c_start = 24'h002000; pan = 8'd5;
    run_frame("R4 R5 top-shift", 0);

    // R6 R9: bottom band of 5 lines overlaps remainder, no shift
    a_en = 0; b_en = 1; b_start = 24'h000400; b_end = 24'h000400 + 24'd24;
    c_start = 24'h003000; pan = 8'd11;
    run_frame("R6 R9 bottom-overlap", 0);

    // R7: both bands 5 lines on an 8-line panel, rows 3..4 contested
    a_en = 1; b_en = 1; a_start = 24'h000500; a_end = 24'h000500 + 24'd26;
    b_start = 24'h000600; b_end = 24'h000600 + 24'd24; c_start = 24'h004000;
    run_frame("R7 priority", 0);

    // R8: same frame, configuration disturbed outside the sampling cycle
    run_frame("R8 frozen-config", 1);

    // R4: top span larger than the panel saturates at the height
    a_en = 1; b_en = 0; a_start = 24'h010000; a_end = 24'h010000 + 24'd400;
    height = 10'd10; width = 10'd4; c_start = 24'h020000; pan = 8'd1;
    run_frame("R4 clamp", 0);

    // R5 R6 R9: both bands small, zero pan, wider panel
    a_en = 1; b_en = 1; a_start = 24'hFFFF00; a_end = 24'hFFFF00 + 24'd9;
    b_start = 24'h030000; b_end = 24'h030000 + 24'd14; c_start = 24'h040000;
    pan = 8'd0; height = 10'd12; width = 10'd5;
    run_frame("R5 R6 R9 mixed", 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_900_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R10 watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule